// File: doc/BRIEF.md
# Burst-Clocked Parity Serial Transmitter

This block pulls 16-bit words from an upstream FIFO and sends each one on a three-wire serial link: a gated bit clock, a data line and a frame strobe. Every word goes out as a 17-bit packet. The data bits come first, least significant bit first, and a parity bit comes last. The bit clock runs only while packet bits are being shifted. Outside a transfer, the clock, data and strobe all rest low.

A mode input selects one packet or two packets per transfer. In two-packet mode the second packet follows the first with no idle bit time, and the strobe stays high across both packets. The parity sense is selectable. The bit period is set by a half-period count of system clocks. With an 8 MHz system clock, a count of 64 gives the base rate of 62.5 kHz. Data changes when the bit clock falls and is stable while it is high. A one-cycle done pulse marks the end of each transfer and can serve as the interrupt.

The word input is valid/ready. The block raises `in_ready` only in a cycle where it takes `in_data`, and only while `in_valid` is high. A side input `in_two_avail` reports that the FIFO holds at least two words. A two-packet transfer starts only when that flag is set. Upstream must then present the second word at the end of the first packet, in the cycle the block raises `in_ready` again. Back-pressure is therefore absolute: a word offered while the block is busy waits until the block asks for it.

Top module: `ser_burst_tx`

## Requirements
- R1: After reset and while no transfer is running, `sclk`, `sdata`, `strobe`, `done` and `in_ready` are all low.
- R2: A packet carries 17 bits, one for each rising edge of `sclk`. Bits 0 to 15 are the word's bits 0 to 15 in that order, and bit 16 is the parity bit.
- R3: With `parity_odd`=0, the parity bit equals the XOR of the 16 data bits, so the packet holds an even number of ones.
- R4: With `parity_odd`=1, the parity bit is the inverse of that XOR, so the packet holds an odd number of ones.
- R5: Each high phase and each low phase of `sclk` lasts `half_div` system clocks. Consecutive rising edges are 2×`half_div` clocks apart. A `half_div` of 0 acts as 1.
- R6: `sdata` changes only in the cycle where `sclk` falls, or where `strobe` rises or falls. It is stable at every rising edge of `sclk` and while `sclk` stays high.
- R7: With `mode_dword`=1, one transfer sends two packets, 34 rising edges in all. The strobe is high without a break, and the rising-edge spacing does not widen between the packets.
- R8: A transfer starts only when `in_valid` is high and, with `mode_dword`=1, `in_two_avail` is also high. Otherwise the outputs stay idle.
- R9: `in_ready` is high only while `in_valid` is high. It is high exactly once per packet sent.
- R10: `strobe` is high for exactly 34×`half_div` system clocks per packet (68×`half_div` for two packets). `sclk` is high only while `strobe` is high.
- R11: `done` is high for exactly one cycle per transfer, in the first cycle after `strobe` falls.
- R12: `mode_dword`, `parity_odd` and `half_div` are captured when a transfer starts. Changes to them during the transfer do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | 16 | Word offered by the FIFO |
| in_valid | input | 1 | FIFO holds at least one word |
| in_two_avail | input | 1 | FIFO holds at least two words |
| in_ready | output | 1 | Word taken this cycle (FIFO pop) |
| mode_dword | input | 1 | 1: two packets per transfer, 0: one |
| parity_odd | input | 1 | 1: odd parity, 0: even parity |
| half_div | input | 16 | System clocks per half bit period (0 acts as 1) |
| sclk | output | 1 | Gated serial bit clock |
| sdata | output | 1 | Serial data line |
| strobe | output | 1 | High for the duration of a transfer |
| done | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Single packets are sent with these data patterns:
- An alternating pattern with an even bit count, under even and then odd parity. This separates the two parity senses and shows bit order.
- A single-one pattern. This exposes a reversed bit order or a shift by one.
- All-ones and all-zeros words. These show that parity is computed over exactly 16 bits.

Two-packet transfers use two different words, so the packet order and the seamless join are both visible.

Further runs cover:
- A start held off because only one word is available in two-packet mode.
- Control inputs changed in the middle of a transfer.
- A zero divider and the default 64-clock half period. These tell apart a divider that miscounts by one from one that ignores its setting.

// File: rtl/ser_tx_pkg.sv
package ser_tx_pkg;
  localparam int WORD_W = 16;
  localparam int PKT_W  = WORD_W + 1;
  typedef logic [WORD_W-1:0] word_t;

  // parity bit appended after the data bits
  function automatic logic pkt_parity(input word_t d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/ser_tx_baud.sv
module ser_tx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = run && (cnt == div_val - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ser_tx_shreg.sv
module ser_tx_shreg
  import ser_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t load_data,
  input  logic  odd,
  input  logic  shift,
  output logic  ser_bit
);
  logic [PKT_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n)      sh <= '0;
    else if (load)   sh <= {pkt_parity(load_data, odd), load_data};
    else if (shift)  sh <= sh >> 1;
  end

  assign ser_bit = sh[0];
endmodule

// File: rtl/ser_burst_tx.sv
module ser_burst_tx
  import ser_tx_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      in_data,
  input  logic             in_valid,
  input  logic             in_two_avail,
  output logic             in_ready,
  input  logic             mode_dword,
  input  logic             parity_odd,
  input  logic [DIV_W-1:0] half_div,
  output logic             sclk,
  output logic             sdata,
  output logic             strobe,
  output logic             done
);
  localparam int IDX_W = $clog2(PKT_W);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_W - 1);

  logic             busy, phase_hi, pend, odd_q, done_q;
  logic [DIV_W-1:0] div_q;
  logic [IDX_W-1:0] bit_idx;
  logic             tick, start_ok, end_bit, last_bit, reload, ser_bit;

  assign start_ok = !busy && in_valid && (!mode_dword || in_two_avail);
  assign last_bit = (bit_idx == LAST_IDX);
  assign end_bit  = busy && phase_hi && tick;
  assign reload   = end_bit && last_bit && pend;
  assign in_ready = start_ok || reload;

  ser_tx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .div_val(div_q), .tick(tick)
  );

  ser_tx_shreg shreg_i (
    .clk(clk), .rst_n(rst_n),
    .load(in_ready), .load_data(in_data),
    .odd(start_ok ? parity_odd : odd_q),
    .shift(end_bit && !last_bit),
    .ser_bit(ser_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      phase_hi <= 1'b0;
      pend     <= 1'b0;
      odd_q    <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= DIV_W'(1);
      bit_idx  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_ok) begin
        busy     <= 1'b1;
        phase_hi <= 1'b0;
        bit_idx  <= '0;
        pend     <= mode_dword;
        odd_q    <= parity_odd;
        div_q    <= (half_div == '0) ? DIV_W'(1) : half_div;
      end else if (busy && tick) begin
        if (!phase_hi) begin
          phase_hi <= 1'b1;
        end else begin
          phase_hi <= 1'b0;
          if (last_bit) begin
            bit_idx <= '0;
            if (pend) pend <= 1'b0;
            else begin
              busy   <= 1'b0;
              done_q <= 1'b1;
            end
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
      end
    end
  end

  assign sclk   = busy && phase_hi;
  assign sdata  = busy && ser_bit;
  assign strobe = busy;
  assign done   = done_q;
endmodule

// File: rtl/ser_burst_tx_chk.sv
module ser_burst_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic sclk,
  input logic sdata,
  input logic strobe,
  input logic done
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (!sclk && !sdata));

  p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdata));

  p_hold_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(sdata));

  p_pop_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> in_valid);

  p_clk_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> strobe);

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> done);
endmodule

bind ser_burst_tx ser_burst_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .sclk(sclk), .sdata(sdata), .strobe(strobe), .done(done)
);

// File: tb/ser_burst_tx_tb_top.sv
module ser_burst_tx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_dword = 1'b0, parity_odd = 1'b0;
  logic [15:0] half_div = 16'd2;
  logic        in_ready, sclk, sdata, strobe, done;
  logic [15:0] in_data;
  logic        in_valid, in_two_avail;

  always #2 clk = ~clk;

  // FIFO model
  logic [15:0] fq [0:7];
  int wp = 0, rp = 0;
  assign in_valid     = (wp != rp);
  assign in_two_avail = (wp - rp) >= 2;
  assign in_data      = fq[rp % 8];
  always @(posedge clk) if (in_ready) rp <= rp + 1;

  ser_burst_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .in_two_avail(in_two_avail), .in_ready(in_ready),
    .mode_dword(mode_dword), .parity_odd(parity_odd), .half_div(half_div),
    .sclk(sclk), .sdata(sdata), .strobe(strobe), .done(done)
  );

  int checks = 0, errors = 0;

  // monitor sampling away from the active edge
  logic bits [0:63];
  int   rc   [0:63];
  int   nbits = 0, hi_cyc = 0, done_cyc = 0, done_bad = 0, pops = 0;
  int   cyc = 0;
  logic sclk_p = 1'b0;
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sclk && !sclk_p && nbits < 64) begin
      bits[nbits] = sdata;
      rc[nbits]   = cyc;
      nbits = nbits + 1;
    end
    sclk_p = sclk;
    if (strobe) hi_cyc = hi_cyc + 1;
    if (done) begin
      done_cyc = done_cyc + 1;
      if (strobe) done_bad = done_bad + 1;
    end
    if (in_ready) pops = pops + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    nbits = 0; hi_cyc = 0; done_cyc = 0; done_bad = 0; pops = 0;
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    fq[wp % 8] = w;
    wp = wp + 1;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cyc == 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 20000) chk(0, "WATCHDOG", n, 0);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic par(input logic [15:0] w, input logic odd);
    return (^w) ^ odd;
  endfunction

  task automatic check_frame(input logic [15:0] w0, input logic [15:0] w1,
                             input bit dbl, input logic odd, input int h);
    int np = dbl ? 2 : 1;
    int bad = 0, gap_bad = 0;
    chk(nbits == 17 * np, dbl ? "R7 edge count" : "R2 edge count", nbits, 17 * np);
    for (int p = 0; p < np; p++) begin
      logic [15:0] w = (p == 0) ? w0 : w1;
      for (int i = 0; i < 16; i++)
        if (bits[p*17+i] !== w[i]) bad++;
      chk(bits[p*17+16] === par(w, odd), odd ? "R4 parity" : "R3 parity",
          bits[p*17+16], par(w, odd));
    end
    chk(bad == 0, "R2 data order", bad, 0);
    for (int i = 1; i < 17 * np && i < nbits; i++)
      if (rc[i] - rc[i-1] != 2 * h) gap_bad++;
    chk(gap_bad == 0, "R5/R7 edge spacing", gap_bad, 0);
    chk(hi_cyc == 34 * h * np, "R10 strobe width", hi_cyc, 34 * h * np);
    chk(done_cyc == 1 && done_bad == 0, "R11 done pulse", done_cyc, 1);
    chk(pops == np, "R9 pops per packet", pops, np);
  endtask

  task automatic t_reset();
    chk({sclk, sdata, strobe, done, in_ready} == 5'b0, "R1 idle after reset",
        {sclk, sdata, strobe, done, in_ready}, 0);
  endtask

  task automatic t_single(input logic [15:0] w, input logic odd, input logic [15:0] h);
    mode_dword = 1'b0; parity_odd = odd; half_div = h;
    clear_mon();
    push(w);
    wait_done();
    check_frame(w, 16'h0, 0, odd, (h == 0) ? 1 : int'(h));
    chk({sclk, sdata, strobe} == 3'b0, "R1 idle after frame", {sclk, sdata, strobe}, 0);
  endtask

  task automatic t_double(input logic [15:0] a, input logic [15:0] b, input logic odd);
    mode_dword = 1'b1; parity_odd = odd; half_div = 16'd3;
    clear_mon();
    @(negedge clk);
    fq[wp % 8] = a; fq[(wp + 1) % 8] = b; wp = wp + 2;
    wait_done();
    check_frame(a, b, 1, odd, 3);
  endtask

  task automatic t_nostart();
    mode_dword = 1'b1; parity_odd = 1'b0; half_div = 16'd2;
    clear_mon();
    push(16'h1234);
    repeat (20) @(negedge clk);
    chk(hi_cyc == 0 && pops == 0, "R8 no start with one word", hi_cyc, 0);
    mode_dword = 1'b0;
    wait_done();
    check_frame(16'h1234, 16'h0, 0, 0, 2);
  endtask

  task automatic t_latch();
    mode_dword = 1'b0; parity_odd = 1'b0; half_div = 16'd2;
    clear_mon();
    push(16'h00F1);
    while (!strobe) @(negedge clk);
    repeat (5) @(negedge clk);
    parity_odd = 1'b1; half_div = 16'd5; mode_dword = 1'b1;
    push(16'hBEEF);
    wait_done();
    chk(hi_cyc == 68 && nbits == 17, "R12 controls latched", hi_cyc, 68);
    check_frame(16'h00F1, 16'h0, 0, 0, 2);
    mode_dword = 1'b0;
    clear_mon();
    wait_done();
    check_frame(16'hBEEF, 16'h0, 0, 1, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_single(16'hA5A5, 1'b0, 16'd2);
    t_single(16'hA5A5, 1'b1, 16'd2);
    t_single(16'h0001, 1'b0, 16'd1);
    t_single(16'hFFFF, 1'b1, 16'd3);
    t_single(16'h0000, 1'b0, 16'd0);
    t_double(16'h8001, 16'h7E3C, 1'b0);
    t_double(16'h0F0F, 16'h0001, 1'b1);
    t_nostart();
    t_latch();
    t_single(16'hC3A1, 1'b0, 16'd64);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1500000;
    chk(0, "WATCHDOG global", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule